// File: doc/BRIEF.md
# Select-Gated SPI Byte Slave

This block is an SPI slave that exchanges one byte with an external master per transfer. All bit timing comes from the master's serial clock. The block runs on a faster system clock and oversamples the serial clock, data-in and select pins. Clock polarity, clock phase and bit order come from a small control register. A transmit buffer feeds an internal shifter. The shifter delivers each completed received byte to a receive buffer. A one-bit capture register holds each incoming data bit from the sampling edge until the next shifting edge, when the bit enters the shifter.

The active-low select gates everything. While select is high, the block ignores the serial clock and data-in. It also clears its bit counter and drives data-out high, so several slaves can share the line in wired-AND fashion. When a transfer samples on the first clock edge (CPHA=0), the falling edge of select loads the transmit buffer into the shifter, so the first bit is on the line before any clock edge arrives. If no byte is queued when a byte starts, the block sends all ones. If select rises part-way through a byte, the block drops the partial byte without any sign.

Top module: `spi_sel_slave`

## Requirements
- R1: With select low, eight clock cycles exchange one byte full duplex in every combination of CPOL (control bit 1, idle level of SCLK) and CPHA (control bit 0; 0 = sample on the leading edge, 1 = sample on the trailing edge).
- R2: Bits move MSb first when control bit 2 is 0, and LSb first when it is 1, in both directions.
- R3: While select is high, MISO is 1.
- R4: While select is high, SCLK and MOSI activity sets no flag and changes neither buffer.
- R5: A select rise in the middle of a byte discards the partial byte and sets no flag. The next transfer starts aligned at bit 0.
- R6: With CPHA=0, the falling edge of select loads the transmit buffer, and MISO shows the first bit before the first SCLK edge.
- R7: After the 8th bit, the received byte appears at address 2, and status bit 5 (RX full) and bit 6 (done) set. Reading address 0 clears done. Reading address 2 clears RX full.
- R8: Status bit 4 (TX empty) is 1 after reset. A write to address 1 clears it, and loading the byte into the shifter sets it again.
- R9: A byte that starts while TX empty is set is transmitted as 0xFF.
- R10: Writes to address 2 are ignored, and reads of address 1 return 0.
- R11: With select held low, a byte queued during a transfer is sent in the next byte, with no gap.
- R12: Status reads at address 0 return the control bits [2:0] as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from master |
| mosi_i | input | 1 | Serial data from master |
| ssel_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to master |
| bus_addr | input | 2 | Register address: 0 control/status, 1 TX, 2 RX |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |

## Verification
The bench aborts a byte after four bits and then runs a full byte. A design that kept its bit count across the select rise would return a byte rotated by four bits, or would raise done early. In the CPHA=0 modes, the bench reads MISO after select falls and before any clock edge. A design that loaded only on a clock edge would show a stale or idle bit there. The bench also toggles the clock with select high to catch designs that count bits while deselected. It queues a second byte mid-transfer to catch designs that reload only on a select edge. Finally, it runs a byte with nothing queued to catch designs that resend stale data instead of all ones.

// File: rtl/spi_sel_pkg.sv
// Shared types and constants for the select-gated SPI slave.
// Assumes a byte-wide register bus with a 2-bit address.
package spi_sel_pkg;

    // Transfer configuration held in the control register.
    typedef struct packed {
        logic lsb_first;
        logic cpol;
        logic cpha;
    } spi_cfg_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TX   = 2'd1;
    localparam logic [1:0] ADDR_RX   = 2'd2;

    localparam int ST_TX_EMPTY = 4;
    localparam int ST_RX_FULL  = 5;
    localparam int ST_DONE     = 6;

endpackage

// File: rtl/spi_sel_sync.sv
// Multi-stage synchronizer for asynchronous pins.
// Each bit is handled on its own; the block assumes the bits carry no
// relationship that needs to be kept across the crossing.
module spi_sel_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop: samples the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= d_i;
            end
        end else begin : g_next
            // Later flops: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    assign q_o = stage[STAGES-1];
endmodule

// File: rtl/spi_sel_core.sv
// Bit engine: edge detection on the synchronized SCLK, MOSI capture,
// bit counting, TX shifter and receive assembly. Assumes the system clock
// is at least 4x SCLK, so that sample and shift events are at least two
// system cycles apart.
module spi_sel_core
    import spi_sel_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              ssn_s,
    input  spi_cfg_t          cfg,
    input  logic [DATA_W-1:0] tx_buf,
    input  logic              tx_empty,
    output logic              miso_o,
    output logic              tx_load,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_word,
    output logic              ss_act,
    output logic [CNT_W-1:0]  bitcnt
);
    logic              sclk_d;
    logic              ssn_d;
    logic              cap;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              sclk_edge;
    logic              lead_ev;
    logic              trail_ev;
    logic              sample_ev;
    logic              shift_ev;
    logic              mid_shift;
    logic              ss_fall;

    // Push one bit into a word in the configured direction.
    function automatic logic [DATA_W-1:0] push_bit(
        input logic [DATA_W-1:0] w, input logic b, input logic lsb);
        return lsb ? {b, w[DATA_W-1:1]} : {w[DATA_W-2:0], b};
    endfunction

    // Previous values of SCLK and select, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            ssn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            ssn_d  <= ssn_s;
        end
    end

    // Classify edges and map them onto sample and shift events by phase.
    always_comb begin
        ss_act    = !ssn_s;
        ss_fall   = ssn_d && !ssn_s;
        sclk_edge = sclk_s ^ sclk_d;
        lead_ev   = sclk_edge && (sclk_s != cfg.cpol);
        trail_ev  = sclk_edge && (sclk_s == cfg.cpol);
        sample_ev = ss_act && (cfg.cpha ? trail_ev : lead_ev);
        shift_ev  = ss_act && (cfg.cpha ? lead_ev : trail_ev);
        mid_shift = shift_ev && (bitcnt != '0);
        byte_done = ss_act && (bitcnt == CNT_W'(DATA_W));
        tx_load   = (ss_fall && !cfg.cpha) || (shift_ev && (bitcnt == '0));
        rx_word   = push_bit(rx_sh, cap, cfg.lsb_first);
    end

    // Bit counter: counts samples, cleared at byte end or when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)          bitcnt <= '0;
        else if (!ss_act)    bitcnt <= '0;
        else if (byte_done)  bitcnt <= '0;
        else if (sample_ev)  bitcnt <= bitcnt + 1'b1;
    end

    // Capture register: holds MOSI from the sampling edge to the next shift.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap <= 1'b0;
        else if (sample_ev) cap <= mosi_s;
    end

    // Receive assembly: the held bit enters the shifter on each mid-byte shift.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_sh <= '0;
        else if (mid_shift) rx_sh <= push_bit(rx_sh, cap, cfg.lsb_first);
    end

    // Transmit shifter: loaded at the start of a byte, then shifted out.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_sh <= '1;
        else if (!ss_act)   tx_sh <= '1;
        else if (tx_load)   tx_sh <= tx_empty ? '1 : tx_buf;
        else if (mid_shift) tx_sh <= push_bit(tx_sh, 1'b1, cfg.lsb_first);
    end

    // Output bit: the current head of the shifter; idle high when deselected.
    assign miso_o = ss_act ? (cfg.lsb_first ? tx_sh[0] : tx_sh[DATA_W-1]) : 1'b1;

endmodule

// File: rtl/spi_sel_regs.sv
// Register file: control bits, TX and RX buffers and status flags.
// Reads have side effects (status read clears done, RX read clears RX full).
// Assumes DATA_W >= 8 so that all status bits fit.
module spi_sel_regs
    import spi_sel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_load,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_word,
    output spi_cfg_t          cfg,
    output logic [DATA_W-1:0] tx_buf,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rx_buf,
    output logic              rx_full,
    output logic              xfer_done
);
    logic wr_ctrl, wr_tx, rd_ctrl, rd_rx;

    // Decode the bus strobes per address.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
        wr_tx   = bus_wr && (bus_addr == ADDR_TX);
        rd_ctrl = bus_rd && (bus_addr == ADDR_CTRL);
        rd_rx   = bus_rd && (bus_addr == ADDR_RX);
    end

    // Control register: polarity, phase and bit order.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg <= '0;
        else if (wr_ctrl) cfg <= spi_cfg_t'(bus_wdata[2:0]);
    end

    // TX buffer and empty flag: a write fills it, a shifter load drains it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf   <= '0;
            tx_empty <= 1'b1;
        end else if (wr_tx) begin
            tx_buf   <= bus_wdata;
            tx_empty <= 1'b0;
        end else if (tx_load) begin
            tx_empty <= 1'b1;
        end
    end

    // RX buffer and full flag: filled at byte end, flag cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else if (byte_done) begin
            rx_buf  <= rx_word;
            rx_full <= 1'b1;
        end else if (rd_rx) begin
            rx_full <= 1'b0;
        end
    end

    // Done flag: set at byte end, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)         xfer_done <= 1'b0;
        else if (byte_done) xfer_done <= 1'b1;
        else if (rd_ctrl)   xfer_done <= 1'b0;
    end

    // Read mux: the TX address reads back zero, unused addresses read zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[2:0]         = cfg;
                bus_rdata[ST_TX_EMPTY] = tx_empty;
                bus_rdata[ST_RX_FULL]  = rx_full;
                bus_rdata[ST_DONE]     = xfer_done;
            end
            ADDR_RX: bus_rdata = rx_buf;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_sel_slave.sv
// Top of the select-gated SPI slave: synchronizes the pins and connects
// the bit engine to the register file. Assumes clk is at least 4x SCLK.
module spi_sel_slave
    import spi_sel_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SYNC_STG = 2,
    localparam int CNT_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              ssel_n_i,
    output logic              miso_o,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [2:0]        pins_s;
    spi_cfg_t          cfg;
    logic [DATA_W-1:0] tx_buf;
    logic              tx_empty;
    logic [DATA_W-1:0] rx_buf;
    logic              rx_full;
    logic              xfer_done;
    logic              tx_load;
    logic              byte_done;
    logic [DATA_W-1:0] rx_word;
    logic              ss_act;
    logic [CNT_W-1:0]  bitcnt;

    spi_sel_sync #(
        .W       (3),
        .STAGES  (SYNC_STG),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ssel_n_i, mosi_i, sclk_i}),
        .q_o   (pins_s)
    );

    spi_sel_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[0]),
        .mosi_s    (pins_s[1]),
        .ssn_s     (pins_s[2]),
        .cfg       (cfg),
        .tx_buf    (tx_buf),
        .tx_empty  (tx_empty),
        .miso_o    (miso_o),
        .tx_load   (tx_load),
        .byte_done (byte_done),
        .rx_word   (rx_word),
        .ss_act    (ss_act),
        .bitcnt    (bitcnt)
    );

    spi_sel_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_load   (tx_load),
        .byte_done (byte_done),
        .rx_word   (rx_word),
        .cfg       (cfg),
        .tx_buf    (tx_buf),
        .tx_empty  (tx_empty),
        .rx_buf    (rx_buf),
        .rx_full   (rx_full),
        .xfer_done (xfer_done)
    );

endmodule

// File: rtl/spi_sel_checker.sv
// Property checker for the select-gated SPI slave, bound to the top.
module spi_sel_checker #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ss_act,
    input logic              miso_o,
    input logic [CNT_W-1:0]  bitcnt,
    input logic              byte_done,
    input logic              xfer_done,
    input logic              rx_full,
    input logic              tx_empty,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] rx_buf
);
    p_miso_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_act |-> miso_o);

    p_done_needs_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $past(ss_act));

    p_count_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_act |=> (bitcnt == '0));

    p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= CNT_W'(DATA_W));

    p_done_with_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> rx_full);

    p_write_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> !tx_empty);

    p_rx_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !byte_done) |=> $stable(rx_buf));

endmodule

bind spi_sel_slave spi_sel_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ss_act    (ss_act),
    .miso_o    (miso_o),
    .bitcnt    (bitcnt),
    .byte_done (byte_done),
    .xfer_done (xfer_done),
    .rx_full   (rx_full),
    .tx_empty  (tx_empty),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .rx_buf    (rx_buf)
);

// File: tb/spi_sel_slave_bench.sv
// Directed bench: one task per scenario, with a behavioural SPI master.
module spi_sel_slave_bench;
    localparam int HALF = 100;   // SCLK half period in ns (10 system clocks)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       ssel_n = 1'b1;
    logic       miso;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails = 0;
    logic m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;

    always #5 clk = ~clk;

    spi_sel_slave u_spi_sel_slave (
        .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .mosi_i (mosi),
        .ssel_n_i (ssel_n), .miso_o (miso), .bus_addr (bus_addr),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] cfg);
        bus_write(2'd0, {5'b0, cfg});
        m_cpha = cfg[0]; m_cpol = cfg[1]; m_lsb = cfg[2];
        @(negedge clk);
        sclk = m_cpol;
        #(2 * HALF);
    endtask

    task automatic sel(input logic lvl);
        @(negedge clk);
        ssel_n = lvl;
        #(2 * HALF);
    endtask

    // Master: clocks nbits, driving out_b and collecting MISO into in_b.
    task automatic xfer(input logic [7:0] out_b, input int nbits, output logic [7:0] in_b);
        in_b = 8'h00;
        @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            int idx = m_lsb ? k : 7 - k;
            if (!m_cpha) begin
                mosi = out_b[idx];
                #HALF sclk = ~m_cpol;
                in_b[idx] = miso;
                #HALF sclk = m_cpol;
            end else begin
                sclk = ~m_cpol;
                mosi = out_b[idx];
                #HALF sclk = m_cpol;
                in_b[idx] = miso;
                #HALF;
            end
        end
        #HALF;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R3 miso idle after reset", {7'b0, miso}, 8'h01);
        bus_read(2'd0, d);
        chk("R8 status after reset", d, 8'h10);
    endtask

    task automatic t_mode(input logic [2:0] cfg, input logic [7:0] txv, input logic [7:0] rxv);
        logic [7:0] d, got;
        set_cfg(cfg);
        bus_write(2'd1, txv);
        bus_read(2'd0, d);
        chk("R8 write clears empty", d, {5'b0, cfg});
        sel(1'b0);
        if (!cfg[0]) begin
            chk("R6 first bit at select", {7'b0, miso}, {7'b0, cfg[2] ? txv[0] : txv[7]});
            bus_read(2'd0, d);
            chk("R8 select load sets empty", d, 8'h10 | {5'b0, cfg});
        end
        xfer(rxv, 8, got);
        sel(1'b1);
        chk("R1 R2 master received", got, txv);
        bus_read(2'd0, d);
        chk("R7 R12 status after byte", d, 8'h70 | {5'b0, cfg});
        bus_read(2'd2, d);
        chk("R1 R2 slave received", d, rxv);
        bus_read(2'd0, d);
        chk("R7 flags cleared by reads", d, 8'h10 | {5'b0, cfg});
    endtask

    task automatic t_tx_empty();
        logic [7:0] d, got;
        set_cfg(3'b011);
        bus_read(2'd0, d);
        chk("R8 empty before byte", d, 8'h13);
        sel(1'b0);
        xfer(8'h12, 8, got);
        sel(1'b1);
        chk("R9 all ones when empty", got, 8'hFF);
        bus_read(2'd2, d);
        chk("R9 receive still works", d, 8'h12);
        bus_read(2'd0, d);
    endtask

    task automatic t_abort();
        logic [7:0] d, got;
        set_cfg(3'b000);
        bus_write(2'd1, 8'h5A);
        sel(1'b0);
        xfer(8'hFF, 4, got);
        sel(1'b1);
        chk("R3 miso high after abort", {7'b0, miso}, 8'h01);
        bus_read(2'd0, d);
        chk("R5 no flags after abort", d, 8'h10);
        bus_write(2'd1, 8'hC3);
        sel(1'b0);
        xfer(8'h81, 8, got);
        sel(1'b1);
        chk("R5 aligned tx after abort", got, 8'hC3);
        bus_read(2'd2, d);
        chk("R5 aligned rx after abort", d, 8'h81);
        bus_read(2'd0, d);
    endtask

    task automatic t_idle();
        logic [7:0] d;
        int bad = 0;
        set_cfg(3'b000);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            mosi = k[1];
            sclk = ~sclk;
            #HALF;
            if (miso !== 1'b1) bad++;
        end
        sclk = 1'b0;
        #(2 * HALF);
        chk("R3 miso high while deselected", 8'(bad), 8'h00);
        bus_read(2'd0, d);
        chk("R4 no flags while deselected", d, 8'h10);
        bus_read(2'd2, d);
        chk("R4 rx buffer unchanged", d, 8'h81);
    endtask

    task automatic t_bus();
        logic [7:0] d;
        bus_write(2'd2, 8'hEE);
        bus_read(2'd2, d);
        chk("R10 rx write ignored", d, 8'h81);
        bus_write(2'd1, 8'h77);
        bus_read(2'd1, d);
        chk("R10 tx reads zero", d, 8'h00);
        bus_read(2'd0, d);
        chk("R8 tx queued", d, 8'h00);
    endtask

    task automatic t_back_to_back();
        logic [7:0] d, got;
        set_cfg(3'b000);
        bus_write(2'd1, 8'h69);
        sel(1'b0);
        bus_read(2'd0, d);
        chk("R8 empty after select load", d, 8'h10);
        bus_write(2'd1, 8'h0F);
        xfer(8'hF0, 8, got);
        chk("R11 first byte out", got, 8'h69);
        bus_read(2'd2, d);
        chk("R11 first byte in", d, 8'hF0);
        xfer(8'h33, 8, got);
        sel(1'b1);
        chk("R11 second byte out", got, 8'h0F);
        bus_read(2'd2, d);
        chk("R11 second byte in", d, 8'h33);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_mode(3'b000, 8'h5A, 8'hC3);
        t_mode(3'b001, 8'h96, 8'h1E);
        t_mode(3'b110, 8'h3C, 8'hA7);
        t_mode(3'b111, 8'hE1, 8'h48);
        t_mode(3'b100, 8'h2D, 8'hB4);
        t_tx_empty();
        t_abort();
        t_idle();
        t_bus();
        t_back_to_back();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule